// File: doc/BRIEF.md
# Programmable-Lane Hit Word Serializer

This block drains 32-bit hit words from an upstream FIFO over a valid/ready handshake. It streams each word over 1, 2, 4 or 8 serial lanes. Every lane is double data rate, so each lane carries a rising-edge bit and a falling-edge bit per clock. The physical DDR output cells sit outside this block. They take the two bits of each lane from `lane_rise_o` and `lane_fall_o`.

A reduced-resolution option drops the six least significant time bits. The 26 bits that remain are sent, and the word is padded with zeros up to a whole number of clocks for the active lane count. A marker flags the clock that carries the first bits of each word.

The lane count and the resolution option are sampled only while no word is in flight. A word that is accepted back-to-back therefore keeps the configuration of the word before it.

Top module: `hit_serializer`

## Requirements
- R1: While reset is asserted and right after it is released, `hit_ready_o` is 1, all lane outputs are 0 and `word_start_o` is 0.
- R2: `lane_sel_i` encodes the active lane count L as 0→1, 1→2, 2→4, 3→8. Lanes with index L or above always output 0.
- R3: Bits leave most significant first. In clock c of a word (c=0 first), active lane j carries transmitted bit c·2L+j on its rising-edge output and bit c·2L+L+j on its falling-edge output. Bit 0 is the MSB.
- R4: In full-resolution mode (`low_res_i`=0) all 32 bits are sent, taking 32/(2L) clocks.
- R5: In reduced mode (`low_res_i`=1) only input bits 31..6 are sent, followed by zero padding. The word takes ceil(26/(2L)) clocks: 13, 7, 4 and 2 for L = 1, 2, 4, 8.
- R6: `hit_ready_o` is high only when the serializer is idle or in the last clock of a word. A word is accepted on a rising edge where valid and ready are both high.
- R7: The first bits of an accepted word appear in the clock after the accepting edge. `word_start_o` is high in that clock only.
- R8: The configuration is sampled only while idle. Changes to the configuration inputs during a word, including across a back-to-back accept, have no effect until the serializer next goes idle.
- R9: When no word is being sent, all lane outputs and `word_start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_data_i | input | 32 | Hit word from FIFO |
| hit_valid_i | input | 1 | Hit word available |
| hit_ready_o | output | 1 | Word accepted on this edge when valid |
| lane_sel_i | input | 2 | Lane count code (1/2/4/8) |
| low_res_i | input | 1 | Drop six low time bits |
| lane_rise_o | output | 8 | Rising-edge bit per lane |
| lane_fall_o | output | 8 | Falling-edge bit per lane |
| word_start_o | output | 1 | First clock of a word |

## Verification
Every result of a word is due a fixed number of clocks after the edge that accepted it. The first bit pair and the marker arrive one clock later. Clock c carries bit pairs c·2L onward. Ready rises again in clock ncyc−1, and the outputs go quiet in clock ncyc unless a new word was taken.

The bench drives inputs just after a rising edge and reads the outputs at the following falling edge. Its expected values come from the bit-index formula, so each check lands in exactly the clock the requirement names. It sweeps all eight configurations over several data patterns. It also changes the configuration inputs mid-word and during a back-to-back accept.

// File: rtl/hit_ser_pkg.sv
package hit_ser_pkg;
  localparam int HIT_W      = 32;
  localparam int LOW_DROP_W = 6;
  localparam int LANE_MAX   = 8;

  function automatic int word_cycles(int word_w, int drop_w, int sel, bit low_res);
    int bits;
    int step;
    bits = low_res ? word_w - drop_w : word_w;
    step = 2 << sel;
    return (bits + step - 1) / step;
  endfunction
endpackage

// File: rtl/hit_ser_cfg.sv
module hit_ser_cfg #(
  parameter int WORD_W = 32,
  parameter int DROP_W = 6,
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             low_res_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             low_res_o,
  output logic [CNT_W-1:0] cycles_o
);
  logic [SEL_W-1:0] sel_q;
  logic             low_res_q;

  // live inputs only while idle
  assign sel_o     = busy_i ? sel_q : sel_i;
  assign low_res_o = busy_i ? low_res_q : low_res_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      low_res_q <= 1'b0;
    end else begin
      sel_q     <= sel_o;
      low_res_q <= low_res_o;
    end
  end

  always_comb begin
    cycles_o = CNT_W'(hit_ser_pkg::word_cycles(WORD_W, DROP_W, int'(sel_o), low_res_o));
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!busy_i || (sel_q == $past(sel_q) && low_res_q == $past(low_res_q))));
endmodule

// File: rtl/hit_ser_shifter.sv
module hit_ser_shifter #(
  parameter int WORD_W = 32,
  parameter int DROP_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              low_res_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] load_word;

  assign load_word = low_res_i ? {data_i[WORD_W-1:DROP_W], {DROP_W{1'b0}}} : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_word;
    else if (shift_i) sh_q <= sh_q << (2 << sel_i);
  end

  assign word_o = sh_q;
endmodule

// File: rtl/hit_ser_lane_map.sv
module hit_ser_lane_map #(
  parameter int WORD_W   = 32,
  parameter int LANE_MAX = 8,
  parameter int SEL_W    = 2
) (
  input  logic [WORD_W-1:0]   word_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                en_i,
  output logic [LANE_MAX-1:0] rise_o,
  output logic [LANE_MAX-1:0] fall_o
);
  localparam int SEL_N = $clog2(LANE_MAX) + 1;

  for (genvar j = 0; j < LANE_MAX; j++) begin : g_lane
    always_comb begin
      rise_o[j] = 1'b0;
      fall_o[j] = 1'b0;
      for (int s = 0; s < SEL_N; s++) begin
        if (en_i && int'(sel_i) == s && j < (1 << s)) begin
          rise_o[j] = word_i[WORD_W-1-j];
          fall_o[j] = word_i[WORD_W-1-(1 << s)-j];
        end
      end
    end
  end
endmodule

// File: rtl/hit_serializer.sv
module hit_serializer #(
  parameter int WORD_W   = hit_ser_pkg::HIT_W,
  parameter int DROP_W   = hit_ser_pkg::LOW_DROP_W,
  parameter int LANE_MAX = hit_ser_pkg::LANE_MAX
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   hit_data_i,
  input  logic                hit_valid_i,
  output logic                hit_ready_o,
  input  logic [$clog2($clog2(LANE_MAX)+1)-1:0] lane_sel_i,
  input  logic                low_res_i,
  output logic [LANE_MAX-1:0] lane_rise_o,
  output logic [LANE_MAX-1:0] lane_fall_o,
  output logic                word_start_o
);
  localparam int SEL_W = $clog2($clog2(LANE_MAX) + 1);
  localparam int CNT_W = $clog2(WORD_W / 2 + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cycles;
  logic              start_q;
  logic              busy, last, accept;
  logic [SEL_W-1:0]  sel_eff;
  logic              low_res_eff;
  logic [WORD_W-1:0] sh_word;

  assign busy        = cnt_q != '0;
  assign last        = cnt_q == CNT_W'(1);
  assign hit_ready_o = !busy || last;
  assign accept      = hit_valid_i && hit_ready_o;

  hit_ser_cfg #(.WORD_W(WORD_W), .DROP_W(DROP_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .busy_i(busy), .sel_i(lane_sel_i), .low_res_i,
    .sel_o(sel_eff), .low_res_o(low_res_eff), .cycles_o(cycles)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else if (accept) begin
      cnt_q   <= cycles;
      start_q <= 1'b1;
    end else begin
      if (busy) cnt_q <= cnt_q - CNT_W'(1);
      start_q <= 1'b0;
    end
  end

  hit_ser_shifter #(.WORD_W(WORD_W), .DROP_W(DROP_W), .SEL_W(SEL_W)) u_shift (
    .clk_i, .rst_ni, .load_i(accept), .shift_i(busy), .data_i(hit_data_i),
    .low_res_i(low_res_eff), .sel_i(sel_eff), .word_o(sh_word)
  );

  hit_ser_lane_map #(.WORD_W(WORD_W), .LANE_MAX(LANE_MAX), .SEL_W(SEL_W)) u_map (
    .word_i(sh_word), .sel_i(sel_eff), .en_i(busy),
    .rise_o(lane_rise_o), .fall_o(lane_fall_o)
  );

  assign word_start_o = start_q;

  // R7
  start_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> word_start_o);
  // R6
  no_ready_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_o |-> !hit_ready_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (lane_rise_o == '0 && lane_fall_o == '0 && !word_start_o));
  // R4
  word_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cnt_q >= CNT_W'(2) && cnt_q <= CNT_W'(WORD_W / 2)));
endmodule

// File: tb/hit_serializer_test.sv
module hit_serializer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] hit_data = '0;
  logic        hit_valid = 1'b0;
  logic        hit_ready;
  logic [1:0]  lane_sel = '0;
  logic        low_res = 1'b0;
  logic [7:0]  lane_rise, lane_fall;
  logic        word_start;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hit_serializer uut (
    .clk_i(clk), .rst_ni, .hit_data_i(hit_data), .hit_valid_i(hit_valid),
    .hit_ready_o(hit_ready), .lane_sel_i(lane_sel), .low_res_i(low_res),
    .lane_rise_o(lane_rise), .lane_fall_o(lane_fall), .word_start_o(word_start)
  );

  function automatic bit tx_bit(logic [31:0] d, bit lr, int k);
    logic [31:0] t;
    t = lr ? {d[31:6], 6'b0} : d;
    return (k < 32) ? t[31-k] : 1'b0;
  endfunction

  function automatic int ncyc(int sel, bit lr);
    int bits;
    bits = lr ? 26 : 32;
    return (bits + (2 << sel) - 1) / (2 << sel);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(logic [31:0] d, int sel, bit lr, int c, bit exp_start,
                             bit exp_ready, string req);
    logic [7:0] er, ef;
    int l;
    l = 1 << sel;
    er = '0;
    ef = '0;
    for (int j = 0; j < l; j++) begin
      er[j] = tx_bit(d, lr, c * 2 * l + j);
      ef[j] = tx_bit(d, lr, c * 2 * l + l + j);
    end
    check(lane_rise == er, req, "rise lanes", 32'(lane_rise), 32'(er));
    check(lane_fall == ef, req, "fall lanes", 32'(lane_fall), 32'(ef));
    check(word_start == exp_start, "R7", "word_start", 32'(word_start), 32'(exp_start));
    check(hit_ready == exp_ready, "R6", "ready in word", 32'(hit_ready), 32'(exp_ready));
  endtask

  task automatic check_idle(string req);
    check(lane_rise == '0 && lane_fall == '0, req, "idle lanes",
          {16'h0, lane_rise, lane_fall}, 32'h0);
    check(word_start == 1'b0, req, "idle start", 32'(word_start), 32'h0);
    check(hit_ready == 1'b1, "R6", "idle ready", 32'(hit_ready), 32'h1);
  endtask

  task automatic run_word(logic [31:0] d, int sel, bit lr, int alt_sel, bit alt_lr, string req);
    int n;
    @(negedge clk);
    hit_data  = d;
    lane_sel  = 2'(sel);
    low_res   = lr;
    hit_valid = 1'b1;
    @(posedge clk);
    #1;
    hit_valid = 1'b0;
    hit_data  = '0;
    lane_sel  = 2'(alt_sel);
    low_res   = alt_lr;
    n = ncyc(sel, lr);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_cycle(d, sel, lr, c, c == 0, c == n - 1, req);
    end
    @(negedge clk);
    check_idle("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    logic [31:0] d1, d2;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'hA5C3_0F96;
    pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_003F;
    pats[4] = 32'h1234_5678;
    hit_valid = 1'b1;
    hit_data  = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(lane_rise == '0 && lane_fall == '0 && !word_start, "R1", "in reset",
          {15'h0, word_start, lane_rise, lane_fall}, 32'h0);
    hit_valid = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    check(hit_ready == 1'b1, "R1", "ready after reset", 32'(hit_ready), 32'h1);
    check(lane_rise == '0 && lane_fall == '0 && !word_start, "R1", "outputs after reset",
          {15'h0, word_start, lane_rise, lane_fall}, 32'h0);

    // R2 R3 R4 R5: sweep all lane counts and both resolutions
    for (int s = 0; s < 4; s++)
      for (int lr = 0; lr < 2; lr++)
        for (int p = 0; p < 5; p++)
          run_word(pats[p], s, bit'(lr), s, bit'(lr), lr ? "R5 R3 R2" : "R4 R3 R2");

    // R8: config inputs change during a word
    run_word(32'hC0DE_BEEF, 3, 1'b0, 0, 1'b1, "R8");
    run_word(32'h0F0F_1234, 0, 1'b1, 3, 1'b0, "R8");

    // R6 R8: back-to-back accept keeps the running configuration
    d1 = 32'h9ABC_DEF0;
    d2 = 32'h3579_BDF1;
    @(negedge clk);
    hit_data  = d1;
    lane_sel  = 2'd2;
    low_res   = 1'b0;
    hit_valid = 1'b1;
    @(posedge clk);
    #1;
    hit_data = d2;
    lane_sel = 2'd3;
    low_res  = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_cycle(d1, 2, 1'b0, c, c == 0, c == 3, "R6");
    end
    @(posedge clk);
    #1;
    hit_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_cycle(d2, 2, 1'b0, c, c == 0, c == 3, "R8");
    end
    @(negedge clk);
    check_idle("R9");
    // new configuration applies once idle
    run_word(d2, 3, 1'b1, 3, 1'b1, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule